// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

A register-mapped CRC accelerator. Software selects one of four polynomials, an input word size of 8, 16 or 32 bits, and optional transforms on the data going in and on the checksum coming out. Each accepted write to the data register advances the CRC state by the selected number of bits in one clock cycle. The result is read back from the checksum register on the next cycle.

To start a new stream, software writes the starting value to the seed register. It then writes the control register with the restart bit set, which copies the seed into the CRC state. Changing mode, size or transform bits without the restart bit leaves the running state untouched, so the word size can change in the middle of a stream.

The bus has one access per cycle. A write happens on the clock edge while `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `crc_accel`

## Requirements
- R1: There are four registers: control at 0x0, data at 0x4, seed at 0x8 and checksum at 0xC. All four read zero after reset. The data and seed registers read back the last word written to them.
- R2: Control bits 31:30 select the polynomial: 00 selects 16-bit 0x1021, 01 selects 8-bit 0x07, 10 selects 16-bit 0x8005 and 11 selects 32-bit 0x04C11DB7. Bits are shifted most significant first with no built-in reflection.
- R3: Control bits 29:28 set the word size. 00 consumes data bits 7:0, 01 consumes bits 15:0, and 10 or 11 consumes bits 31:0. Consumption starts at the highest consumed bit, and the unused upper bits have no effect. The checksum reflects an accepted write on the following cycle.
- R4: Control bit 24 reverses the bit order inside each byte of the incoming word, so 0xAABBCCDD is processed as 0x55DD33BB.
- R5: Control bit 26 inverts the incoming word before it enters the CRC.
- R6: Control bit 25 mirrors the checksum across the polynomial width, and bit 27 inverts it across that width. Checksum bits above the width read zero.
- R7: Writing control with bit 1 set loads the seed into the CRC state and stores the other control bits as written. Bit 1 then reads 1 for exactly two cycles before it clears itself.
- R8: A data write has no effect on the CRC state while control bit 0 (enable) is 0 or while bit 1 still reads 1.
- R9: A control write with bit 1 clear keeps the CRC state, so a stream continues across changes of word size.
- R10: The checksum register is read-only. Writes to 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW (4) | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The assertions assume `bus_addr` and `bus_we` are known in every cycle after reset. They also assume that a single bus access names exactly one register, so a data write and a control write never happen in the same cycle. The bench respects this by driving the bus only on the falling edge and holding `bus_we` high for one cycle per access. It reads registers only after the combinational read path has settled. It also holds `rst_n` low across several edges before the first access.

// File: rtl/crc_accel.sv
module crc_accel #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DATA = AW'(4);
  localparam logic [AW-1:0] A_SEED = AW'(8);
  localparam logic [AW-1:0] A_SUM  = AW'(12);
  localparam logic [1:0]    BUSY_CYC = 2'd2;

  logic        en_q;
  logic [7:0]  cfg_q;
  logic [1:0]  busy_cnt;
  logic [31:0] data_q, seed_q, crc_q;

  wire busy    = busy_cnt != 2'd0;
  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_data = bus_we && bus_addr == A_DATA;
  wire wr_seed = bus_we && bus_addr == A_SEED;
  wire rst_req = wr_ctrl && bus_wdata[1];
  wire accept  = wr_data && en_q && !busy;

  wire [1:0] mode    = cfg_q[7:6];
  wire [1:0] dlen    = cfg_q[5:4];
  wire       sum_cpl = cfg_q[3];
  wire       din_cpl = cfg_q[2];
  wire       sum_rev = cfg_q[1];
  wire       din_rev = cfg_q[0];

  int          wdt, nbits;
  logic [31:0] poly, mask;

  always_comb begin
    case (mode)
      2'd0:    begin wdt = 16; poly = 32'h0000_1021; mask = 32'h0000_FFFF; end
      2'd1:    begin wdt = 8;  poly = 32'h0000_0007; mask = 32'h0000_00FF; end
      2'd2:    begin wdt = 16; poly = 32'h0000_8005; mask = 32'h0000_FFFF; end
      default: begin wdt = 32; poly = 32'h04C1_1DB7; mask = 32'hFFFF_FFFF; end
    endcase
    case (dlen)
      2'd0:    nbits = 8;
      2'd1:    nbits = 16;
      default: nbits = 32;
    endcase
  end

  function automatic logic [31:0] crc_adv(input logic [31:0] s, input logic [31:0] d,
                                          input int nb, input int wd,
                                          input logic [31:0] p, input logic [31:0] m);
    logic [31:0] c;
    logic        fb;
    c = s & m;
    for (int i = 31; i >= 0; i--) begin
      if (i < nb) begin
        fb = c[wd-1] ^ d[i];
        c  = ((c << 1) & m) ^ (fb ? p : 32'h0);
      end
    end
    return c;
  endfunction

  logic [31:0] din_c, din_x, crc_nxt;

  always_comb begin
    din_c = din_cpl ? ~bus_wdata : bus_wdata;
    for (int i = 0; i < 32; i++)
      din_x[i] = din_rev ? din_c[(i & ~7) | (7 - (i & 7))] : din_c[i];
    crc_nxt = crc_adv(crc_q, din_x, nbits, wdt, poly, mask);
  end

  logic [31:0] sum0, sum_rv, sum_out;

  always_comb begin
    sum0   = crc_q & mask;
    sum_rv = '0;
    for (int i = 0; i < 32; i++)
      if (i < wdt) sum_rv[i] = sum0[wdt-1-i];
    sum_out = sum_rev ? sum_rv : sum0;
    if (sum_cpl) sum_out = ~sum_out & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cfg_q    <= '0;
      busy_cnt <= '0;
      data_q   <= '0;
      seed_q   <= '0;
      crc_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[0];
        cfg_q <= bus_wdata[31:24];
      end
      if (rst_req)   busy_cnt <= BUSY_CYC;
      else if (busy) busy_cnt <= busy_cnt - 2'd1;
      if (wr_data) data_q <= bus_wdata;
      if (wr_seed) seed_q <= bus_wdata;
      if (rst_req)     crc_q <= seed_q;
      else if (accept) crc_q <= crc_nxt;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {cfg_q, 22'b0, busy, en_q};
      A_DATA:  bus_rdata = data_q;
      A_SEED:  bus_rdata = seed_q;
      A_SUM:   bus_rdata = sum_out;
      default: bus_rdata = '0;
    endcase
  end

  p_seed_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (crc_q == $past(seed_q)));
  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> bus_rdata[1] || bus_addr != A_CTRL);
  p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(rst_req) && !rst_req) |=> !busy);
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && (!en_q || busy)) |=> $stable(crc_q));
  p_sum_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SUM) |=> $stable(crc_q));
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SUM && wdt < 32) |-> ((bus_rdata >> wdt) == 32'h0));
endmodule

// File: tb/sim_crc_accel.sv
module sim_crc_accel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int tests = 0, fails = 0;
  bit done = 0;

  crc_accel #(.AW(4)) u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                          .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2 clk = ~clk;

  function automatic logic [31:0] cw(input logic [1:0] mode, input logic [1:0] len,
                                     input bit scpl, input bit icpl, input bit srev,
                                     input bit irev, input bit rst, input bit en);
    return {mode, len, scpl, icpl, srev, irev, 22'b0, rst, en};
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] s, input logic [31:0] d,
                                          input int nb, input int wd, input logic [31:0] p);
    logic [31:0] c = s;
    logic [31:0] m = (wd == 32) ? 32'hFFFF_FFFF : ((32'h1 << wd) - 1);
    c = c & m;
    for (int k = nb - 1; k >= 0; k--) begin
      logic top = c[wd-1] ^ d[k];
      c = ((c << 1) & m) ^ (top ? p : 32'h0);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic start(input logic [31:0] seed, input logic [31:0] ctrl);
    wr(4'h8, seed);
    wr(4'h0, ctrl | 32'h3);
    repeat (2) @(negedge clk);
  endtask

  task automatic feed_bytes();
    for (int b = 0; b < 9; b++) wr(4'h4, {24'hDEADBE, 8'h31 + 8'(b)});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v); chk("R1 reset value", v, 32'h0);
    end
    wr(4'h4, 32'h1234_5678); rd(4'h4, v); chk("R1 data readback", v, 32'h1234_5678);
    wr(4'h8, 32'hCAFE_0001); rd(4'h8, v); chk("R1 seed readback", v, 32'hCAFE_0001);
    rd(4'hC, v); chk("R8 disabled write ignored", v, 32'h0);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    start(32'hFFFF_FFFF, cw(2'b11, 2'b00, 1, 0, 0, 0, 0, 1));
    feed_bytes(); rd(4'hC, v); chk("R2 R3 crc32 msb-first", v, 32'hFC89_1918);
    start(32'h0, cw(2'b01, 2'b00, 0, 0, 0, 0, 0, 1));
    feed_bytes(); rd(4'hC, v); chk("R2 crc8", v, 32'h0000_00F4);
    start(32'h0, cw(2'b10, 2'b00, 0, 0, 0, 0, 0, 1));
    feed_bytes(); rd(4'hC, v); chk("R2 crc16", v, 32'h0000_FEE8);
  endtask

  task automatic t_ccitt_widths();
    logic [31:0] v;
    start(32'hFFFF_FFFF, cw(2'b00, 2'b01, 0, 0, 0, 0, 0, 1));
    wr(4'h4, 32'h7777_3132); wr(4'h4, 32'h0000_3334);
    wr(4'h4, 32'h1111_3536); wr(4'h4, 32'hFFFF_3738);
    wr(4'h0, cw(2'b00, 2'b00, 0, 0, 0, 0, 0, 1));
    wr(4'h4, 32'hABCD_EF39);
    rd(4'hC, v); chk("R3 R9 ccitt 16-then-8", v, 32'h0000_29B1);
    wr(4'h0, cw(2'b00, 2'b00, 0, 0, 1, 0, 0, 1));
    rd(4'hC, v); chk("R6 reverse 16", v, 32'h0000_8D94);
    wr(4'h0, cw(2'b00, 2'b00, 1, 0, 1, 0, 0, 1));
    rd(4'hC, v); chk("R6 reverse+complement 16", v, 32'h0000_726B);
    wr(4'h0, cw(2'b01, 2'b00, 1, 0, 0, 0, 0, 1));
    rd(4'hC, v); chk("R6 complement 8", v, 32'h0000_004E);
  endtask

  task automatic t_input_xform();
    logic [31:0] v;
    start(32'h0, cw(2'b11, 2'b10, 0, 0, 0, 1, 0, 1));
    wr(4'h4, 32'hAABB_CCDD);
    rd(4'hC, v); chk("R4 per-byte reversal", v, ref_crc(32'h0, 32'h55DD_33BB, 32, 32, 32'h04C1_1DB7));
    start(32'h1234_5678, cw(2'b11, 2'b11, 0, 1, 0, 0, 0, 1));
    wr(4'h4, 32'h0F0F_1234);
    rd(4'hC, v); chk("R5 input complement", v, ref_crc(32'h1234_5678, 32'hF0F0_EDCB, 32, 32, 32'h04C1_1DB7));
    start(32'hFFFF_FFFF, cw(2'b11, 2'b10, 1, 0, 1, 1, 0, 1));
    wr(4'h4, 32'h3132_3334); wr(4'h4, 32'h3536_3738);
    wr(4'h0, cw(2'b11, 2'b00, 1, 0, 1, 1, 0, 1));
    wr(4'h4, 32'h0000_0039);
    rd(4'hC, v); chk("R4 R6 R9 reflected crc32", v, 32'hCBF4_3926);
  endtask

  task automatic t_restart();
    logic [31:0] v, ctl;
    ctl = cw(2'b10, 2'b01, 0, 0, 0, 0, 0, 1);
    wr(4'h8, 32'hA5A5_1357);
    wr(4'h0, ctl | 32'h2);
    rd(4'h0, v); chk("R7 busy cycle 1", v, ctl | 32'h2);
    wr(4'h4, 32'h0000_FFFF);
    rd(4'h0, v); chk("R7 busy cycle 2", v, ctl | 32'h2);
    @(negedge clk);
    rd(4'h0, v); chk("R7 busy cleared, fields kept", v, ctl);
    rd(4'hC, v); chk("R7 R8 seed loaded, busy write ignored", v, 32'h0000_1357);
    wr(4'h4, 32'h0000_00AB);
    rd(4'hC, v); chk("R3 16-bit update", v, ref_crc(32'h1357, 32'h00AB, 16, 16, 32'h8005));
    ctl = v;
    wr(4'h0, cw(2'b10, 2'b01, 0, 0, 0, 0, 0, 0));
    wr(4'h4, 32'h0000_5555);
    rd(4'hC, v); chk("R8 enable low ignored", v, ctl);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R10 checksum read-only", v, ctl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_ccitt_widths();
    t_input_xform();
    t_restart();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule